// File: doc/BRIEF.md
# Printer Port Register Block (Compatibility Mode)

This block gives a host a byte-wide register window onto a standard printer port running in compatibility mode. A simple synchronous strobe bus (select, write enable, address, write data, combinational read data) reaches three registers: an outgoing data latch, a status register and a control register. The block also keeps a separate incoming data latch. A side input loads that latch, and a data read returns it when the control direction bit is set.

The printer side of the handshake is generated inside the block. A strobe pulse written through the control register clears busy and hands the outgoing byte to a valid/ready byte stream. When the strobe pulse is released, an interrupt can become pending. Later status reads walk the acknowledge bit through its cycle, and the read that ends the cycle clears the interrupt. The stream side has a one-entry holding slot. A strobe that arrives while the slot is still occupied is dropped and counted.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, the data latches are 0, irq and out_valid are low, and drop_cnt is 0.
- R2: Data sits at offset 0, status at offset 1 and control at offset 2. A control write stores the whole byte, and a control read returns it. Writes to the status register are ignored. Any other offset reads as 0xFF and ignores writes.
- R3: A data write loads the outgoing latch. A data read returns the incoming latch when control bit 5 (direction) is 1, and the outgoing latch when it is 0. A high in_capture loads in_data into the incoming latch.
- R4: A control write with bit 2 (init) at 0 forces status to 0xD8: bit 7 (not-busy), bit 6 (acknowledge), bit 4 (online) and bit 3 (not-error) set, and bit 0 (timeout) clear.
- R5: A control write with init, bit 3 (select) and bit 0 (strobe) all at 1 clears status bit 7. If the stored strobe bit was 0, the outgoing latch byte is offered on the stream exactly once.
- R6: A control write whose stored strobe bit is already 1 emits no byte. A control write with select at 0 and init at 1 changes neither status nor the stream.
- R7: A control write with init 1, select 1 and strobe 0 sets the pending interrupt when the stored bit 4 (interrupt enable) is 1. The irq output equals the pending flag.
- R8: A status read while status bit 7 is 0 and the stored strobe bit is 0 does one of two things. If acknowledge is set, it clears acknowledge. Otherwise it sets acknowledge and bit 7 and clears the pending interrupt. Any other status read changes nothing. The read returns the value held before the access.
- R9: out_valid stays high with out_byte stable until out_ready is high. An emitted byte that meets a full slot that is not being accepted in that cycle is dropped, and drop_cnt increments, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the access cycle |
| in_data | input | 8 | Byte for the incoming latch |
| in_capture | input | 1 | Loads in_data into the incoming latch |
| irq | output | 1 | Level interrupt |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Stream sink accepts the byte |
| out_byte | output | 8 | Stream byte |
| drop_cnt | output | DROP_W | Count of dropped strobes |

## Verification
The bench targets the acknowledge walk. It checks a status read that clears acknowledge, a following read that restores acknowledge and busy, and a third read that must do nothing. A design that ignores the stored strobe bit, or that clears the interrupt on the wrong read, fails here with visible status and irq errors. The bench also repeats strobe writes with the strobe bit already stored, expecting no extra stream bytes. It sends a burst of strobes into a stalled slot: a design that overwrites the held byte shows the wrong out_byte, and one without saturation wraps drop_cnt. Unmapped and status writes are followed by reads that would reveal any register they disturbed.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
   localparam int OFS_DATA = 0;
   localparam int OFS_STAT = 1;
   localparam int OFS_CTRL = 2;

   // status bit positions
   localparam int ST_NBUSY  = 7;
   localparam int ST_ACK    = 6;
   localparam int ST_PAPER  = 5;
   localparam int ST_ONLINE = 4;
   localparam int ST_NERR   = 3;
   localparam int ST_TMO    = 0;

   // control bit positions
   localparam int CT_DIR   = 5;
   localparam int CT_IRQEN = 4;
   localparam int CT_SEL   = 3;
   localparam int CT_INIT  = 2;
   localparam int CT_AFD   = 1;
   localparam int CT_STB   = 0;

   localparam logic [7:0] STATUS_RST  = 8'hD9;
   localparam logic [7:0] STATUS_INIT = 8'hD8;
   localparam logic [7:0] CONTROL_RST = 8'h0C;
   localparam logic [7:0] UNMAPPED_RD = 8'hFF;

   typedef struct packed {
      logic wr_data;
      logic wr_ctrl;
      logic rd_stat;
   } prn_acc_t;
endpackage

// File: rtl/prn_bus_decode.sv
module prn_bus_decode
   import prn_port_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        status_q,
   input  logic [7:0]        control_q,
   input  logic [7:0]        dout_q,
   input  logic [7:0]        din_q,
   output prn_acc_t          acc,
   output logic [7:0]        rdata
);
   logic hit_data, hit_stat, hit_ctrl;

   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

   always_comb begin
      acc.wr_data = bus_sel &  bus_we & hit_data;
      acc.wr_ctrl = bus_sel &  bus_we & hit_ctrl;
      acc.rd_stat = bus_sel & ~bus_we & hit_stat;
   end

   always_comb begin
      if (hit_data)      rdata = control_q[CT_DIR] ? din_q : dout_q;
      else if (hit_stat) rdata = status_q;
      else if (hit_ctrl) rdata = control_q;
      else               rdata = UNMAPPED_RD;
   end
endmodule

// File: rtl/prn_status_unit.sv
module prn_status_unit
   import prn_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_wdata,
   input  logic [7:0] control_q,
   input  logic       stat_rd,
   output logic [7:0] status_q,
   output logic       pending_q,
   output logic       emit
);
   logic strobe_ok;

   assign strobe_ok = ctrl_wdata[CT_INIT] & ctrl_wdata[CT_SEL];
   assign emit      = ctrl_wr & strobe_ok & ctrl_wdata[CT_STB] & ~control_q[CT_STB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= STATUS_RST;
         pending_q <= 1'b0;
      end else if (ctrl_wr) begin
         if (!ctrl_wdata[CT_INIT]) begin
            status_q <= STATUS_INIT;
         end else if (ctrl_wdata[CT_SEL]) begin
            if (ctrl_wdata[CT_STB]) status_q[ST_NBUSY] <= 1'b0;
            else if (control_q[CT_IRQEN]) pending_q <= 1'b1;
         end
      end else if (stat_rd && !status_q[ST_NBUSY] && !control_q[CT_STB]) begin
         if (status_q[ST_ACK]) begin
            status_q[ST_ACK] <= 1'b0;
         end else begin
            status_q[ST_ACK]   <= 1'b1;
            status_q[ST_NBUSY] <= 1'b1;
            pending_q          <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/prn_out_slot.sv
module prn_out_slot #(
   parameter int DROP_W   = 4,
   parameter bit DROP_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [7:0]        push_byte,
   input  logic              ready,
   output logic              valid_q,
   output logic [7:0]        byte_q,
   output logic [DROP_W-1:0] drop_q
);
   localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

   logic take, free, lost;

   assign take = valid_q & ready;
   assign free = ~valid_q | ready;
   assign lost = push & ~free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         byte_q  <= '0;
      end else if (push && free) begin
         valid_q <= 1'b1;
         byte_q  <= push_byte;
      end else if (take) begin
         valid_q <= 1'b0;
      end
   end

   generate
      if (DROP_SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       drop_q <= '0;
            else if (lost && drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    drop_q <= '0;
            else if (lost) drop_q <= drop_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
   import prn_port_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DROP_W   = 4,
   parameter bit DROP_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        in_data,
   input  logic              in_capture,
   output logic              irq,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_byte,
   output logic [DROP_W-1:0] drop_cnt
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover offsets 0..2");
      end
      if (DROP_W < 1 || DROP_W > 32) begin : g_bad_drop
         $error("DROP_W out of range");
      end
   endgenerate

   prn_acc_t   acc;
   logic [7:0] control_q, dout_q, din_q, status_q;
   logic       pending_q, emit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         control_q <= CONTROL_RST;
         dout_q    <= '0;
         din_q     <= '0;
      end else begin
         if (acc.wr_ctrl) control_q <= bus_wdata;
         if (acc.wr_data) dout_q    <= bus_wdata;
         if (in_capture)  din_q     <= in_data;
      end
   end

   prn_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .status_q (status_q),
      .control_q(control_q),
      .dout_q   (dout_q),
      .din_q    (din_q),
      .acc      (acc),
      .rdata    (bus_rdata)
   );

   prn_status_unit u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (acc.wr_ctrl),
      .ctrl_wdata(bus_wdata),
      .control_q (control_q),
      .stat_rd   (acc.rd_stat),
      .status_q  (status_q),
      .pending_q (pending_q),
      .emit      (emit)
   );

   prn_out_slot #(.DROP_W(DROP_W), .DROP_SAT(DROP_SAT)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (emit),
      .push_byte(dout_q),
      .ready    (out_ready),
      .valid_q  (out_valid),
      .byte_q   (out_byte),
      .drop_q   (drop_cnt)
   );

   assign irq = pending_q;
endmodule

// File: rtl/prn_port_checker.sv
module prn_port_checker #(
   parameter int ADDR_W = 3,
   parameter int DROP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              irq,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_byte,
   input logic [DROP_W-1:0] drop_cnt
);
   logic wr_ctrl, rd_stat, rd_unmapped;
   assign wr_ctrl     = bus_sel & bus_we & (bus_addr == ADDR_W'(2));
   assign rd_stat     = bus_sel & ~bus_we & (bus_addr == ADDR_W'(1));
   assign rd_unmapped = bus_sel & ~bus_we & (bus_addr > ADDR_W'(2));

   a_r2_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unmapped |-> bus_rdata == 8'hFF);

   a_r5_emit_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(wr_ctrl && bus_wdata[0] && bus_wdata[2] && bus_wdata[3]));

   a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wr_ctrl && !bus_wdata[0]));

   a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(rd_stat));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte));

   a_r9_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> $past(out_valid) && !$past(out_ready));
endmodule

bind prn_port_regs prn_port_checker #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq(irq), .out_valid(out_valid), .out_ready(out_ready),
   .out_byte(out_byte), .drop_cnt(drop_cnt)
);

// File: tb/sim_prn_port_regs.sv
`timescale 1ns/1ps
module sim_prn_port_regs;
   localparam int AW = 3;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0, in_data = '0;
   logic          in_capture = 1'b0, out_ready = 1'b0;
   logic [7:0]    bus_rdata, out_byte;
   logic          irq, out_valid;
   logic [DW-1:0] drop_cnt;

   int checks = 0;
   int errors = 0;

   // reference state derived from the requirements
   logic [7:0]    m_stat, m_ctrl, m_dout, m_din, m_byte;
   logic          m_pend, m_valid;
   int            m_drop;

   always #2.5 clk = ~clk;

   prn_port_regs #(.ADDR_W(AW), .DROP_W(DW)) u0 (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_side(string req);
      chk({req, " irq"}, irq, m_pend);
      chk({req, " valid"}, out_valid, m_valid);
      if (m_valid) chk({req, " byte"}, out_byte, m_byte);
      chk({req, " drops"}, drop_cnt, m_drop);
   endtask

   function automatic logic [7:0] exp_read(int a);
      if (a == 0) return m_ctrl[5] ? m_din : m_dout;
      if (a == 1) return m_stat;
      if (a == 2) return m_ctrl;
      return 8'hFF;
   endfunction

   task automatic mdl_write(int a, logic [7:0] w);
      if (a == 0) m_dout = w;
      else if (a == 2) begin
         if (!w[2]) m_stat = 8'hD8;
         else if (w[3]) begin
            if (w[0]) begin
               m_stat[7] = 1'b0;
               if (!m_ctrl[0]) begin
                  if (!m_valid) begin m_valid = 1'b1; m_byte = m_dout; end
                  else if (m_drop < (1 << DW) - 1) m_drop++;
               end
            end else if (m_ctrl[4]) m_pend = 1'b1;
         end
         m_ctrl = w;
      end
   endtask

   task automatic mdl_stat_read();
      if (!m_stat[7] && !m_ctrl[0]) begin
         if (m_stat[6]) m_stat[6] = 1'b0;
         else begin m_stat[6] = 1'b1; m_stat[7] = 1'b1; m_pend = 1'b0; end
      end
   endtask

   task automatic wr(int a, logic [7:0] w, string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = w;
      @(posedge clk);
      mdl_write(a, w);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      check_side(req);
   endtask

   task automatic rd(int a, string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
      #1 chk({req, " rdata"}, bus_rdata, exp_read(a));
      @(posedge clk);
      if (a == 1) mdl_stat_read();
      @(negedge clk);
      bus_sel = 1'b0;
      check_side(req);
   endtask

   task automatic capture(logic [7:0] v);
      @(negedge clk);
      in_capture = 1'b1; in_data = v;
      @(posedge clk);
      m_din = v;
      @(negedge clk);
      in_capture = 1'b0;
   endtask

   task automatic drain(string req);
      @(negedge clk);
      out_ready = 1'b1;
      chk({req, " drain valid"}, out_valid, m_valid);
      if (m_valid) chk({req, " drain byte"}, out_byte, m_byte);
      @(posedge clk);
      m_valid = 1'b0;
      @(negedge clk);
      out_ready = 1'b0;
      check_side(req);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h5EED1);
      m_stat = 8'hD9; m_ctrl = 8'h0C; m_dout = 0; m_din = 0; m_byte = 0;
      m_pend = 0; m_valid = 0; m_drop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_side("R1");
      rd(1, "R1"); rd(2, "R1"); rd(0, "R1");

      // R5 / R7 / R8 handshake walk
      wr(0, 8'hA5, "R3");
      wr(2, 8'h1D, "R5");
      chk("R5 busy cleared", out_valid, 1'b1);
      wr(2, 8'h1D, "R6");
      wr(2, 8'h1C, "R7");
      chk("R7 irq set", irq, 1'b1);
      rd(1, "R8");
      rd(1, "R8");
      chk("R8 irq cleared", irq, 1'b0);
      rd(1, "R8");
      drain("R9");

      // R6 select low: nothing happens
      wr(2, 8'h04, "R6");
      wr(2, 8'h05, "R6");
      rd(1, "R6");

      // R9 stalled slot, drops saturate
      wr(2, 8'h0C, "R9");
      wr(0, 8'h3C, "R9");
      wr(2, 8'h0D, "R9");
      for (int i = 0; i < 18; i++) begin
         wr(2, 8'h0C, "R9");
         wr(0, 8'(i), "R9");
         wr(2, 8'h0D, "R9");
      end
      chk("R9 saturated", drop_cnt, 4'hF);
      drain("R9");

      // R2 unmapped and status writes ignored
      wr(5, 8'h00, "R2");
      wr(1, 8'h00, "R2");
      rd(5, "R2"); rd(7, "R2"); rd(1, "R2"); rd(2, "R2"); rd(0, "R2");

      // R3 direction
      capture(8'hC3);
      wr(2, 8'h2C, "R3");
      rd(0, "R3");
      wr(2, 8'h0C, "R3");
      rd(0, "R3");

      // R4 init low
      wr(2, 8'h08, "R4");
      rd(1, "R4");

      // random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         logic [7:0] v;
         op = int'($urandom % 8);
         v = 8'($urandom);
         case (op)
            0: wr(0, v, "R3");
            1, 2: begin
               if ($urandom % 4 != 0) v[3:2] = 2'b11;
               wr(2, v, "R5");
            end
            3, 4: rd(1, "R8");
            5: rd(int'($urandom % 8), "R2");
            6: capture(v);
            default: drain("R9");
         endcase
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule